// File: doc/BRIEF.md
# System Clock Source and Divider Selector

This block produces the bus clock enable for a small microcontroller. The block runs on the main oscillator clock. It emits a one-cycle enable pulse stream, `bus_en`, that the rest of the chip uses to qualify its flops. The pulses come either from the main clock divided by 1, 2, 4, 8 or 16, or from a slow sub oscillator. The sub oscillator is presented as a synchronized one-cycle strobe, `sub_tick`. The block never gates a clock.

A six-bit control word selects the mode. The word is written through `cfg_wr` and `cfg_wdata` and can be read back on `cfg_rdata`. The control word is decoded by priority: first the sub-source select, then the divide-by-8 override bit, then the two-bit divider code. A decoded request does not take effect at once. It is held until two conditions meet in the same cycle: the destination oscillator reports stable, and the current pulse period ends. Only then does it become the active mode. After reset the block runs at divide by 8. Entering stop mode from a main-clock mode sets the override bit again, so the block resumes at divide by 8. Stop mode is requested on `stop_req`.

Top module: `busclk_sel`

## Requirements
- R1: After reset `cfg_rdata` reads 6'b000100, `act_mode` is 3 (divide by 8), `src_sub` is 0 and `main_en` is 1. `bus_en` then pulses once every 8 clock cycles.
- R2: The control word layout is: bit 5 sub-source select, bit 4 sub oscillator on, bit 3 low-power, bit 2 divide-by-8 override, bits 1:0 divider code. With bits 5, 3 and 2 all 0, codes 0, 1, 2 and 3 give `bus_en` periods of 1, 2, 4 and 16 cycles. The matching `act_mode` values are 0, 1, 2 and 4.
- R3: With bit 5 = 0, bit 3 = 0 and bit 2 = 1, the period is 8 cycles and `act_mode` is 3, whatever the divider code.
- R4: With bits 5 and 4 set and bit 3 clear, `act_mode` is 5 and `src_sub` is 1. `bus_en` rises one cycle after each `sub_tick`, and bits 2:0 have no effect.
- R5: With bits 5, 4 and 3 set, `act_mode` is 6 (low power), `src_sub` is 1, `main_en` is 0, and `bus_en` follows `sub_tick`.
- R6: A request for a main-clock mode is held while `main_stable` is 0. The old mode and period stay in effect and `mode_match` is 0. The request is applied once `main_stable` is 1.
- R7: A request for a sub-clock mode is held while `sub_stable` is 0, and is applied once `sub_stable` is 1.
- R8: A control word outside the mode table is rejected. Examples are bit 5 set with bit 4 clear, or bit 3 set with bit 5 clear. The active mode is kept and `mode_match` is 0.
- R9: A divider change takes effect only when the current period ends. The interval in progress keeps its old length and the following intervals use the new length.
- R10: While `stop_req` is 1, `bus_en` stays 0. Entering stop from a main-clock mode sets bit 2 of the control word and makes divide by 8 the active mode.
- R11: Entering stop from a sub-clock mode leaves the control word and the active mode unchanged.
- R12: `mode_match` is 1 when the active mode equals a valid decoded request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 6 | Control word write data |
| cfg_rdata | output | 6 | Control word readback |
| main_stable | input | 1 | Main oscillator stable |
| sub_stable | input | 1 | Sub oscillator stable |
| sub_tick | input | 1 | One-cycle strobe per sub clock period |
| stop_req | input | 1 | Stop mode request (level) |
| bus_en | output | 1 | Bus clock enable pulse |
| src_sub | output | 1 | Bus clock taken from the sub source |
| main_en | output | 1 | Main oscillator enable |
| act_mode | output | 3 | Active mode code |
| mode_match | output | 1 | Active mode equals the request |

## Verification
Two events can fall in the same cycle: a pending mode change waiting for its period boundary, and the boundary itself. The bench provokes this by writing a faster divider code partway through a 16-cycle period. It then counts the interval that follows, which must still be 16 cycles, and checks that the next interval is the new 2-cycle period. A second collision is a stop request arriving while the divider is running. There the bench checks that no enable pulse slips through and that the override bit reads set at once.

// File: rtl/busclk_pkg.sv
package busclk_pkg;
  typedef enum logic [2:0] {
    M_DIV1   = 3'd0,
    M_DIV2   = 3'd1,
    M_DIV4   = 3'd2,
    M_DIV8   = 3'd3,
    M_DIV16  = 3'd4,
    M_SUB    = 3'd5,
    M_LOWPWR = 3'd6
  } mode_e;

  localparam int CFG_W  = 6;
  localparam int SEL_B  = 5;
  localparam int ON_B   = 4;
  localparam int LP_B   = 3;
  localparam int D8_B   = 2;
  localparam logic [CFG_W-1:0] CFG_RST = 6'b000100;

  function automatic logic is_sub(mode_e m);
    return (m == M_SUB) || (m == M_LOWPWR);
  endfunction
endpackage

// File: rtl/busclk_mode_dec.sv
module busclk_mode_dec
  import busclk_pkg::*;
(
  input  logic [CFG_W-1:0] cfg,
  output mode_e            req,
  output logic             req_ok
);
  always_comb begin
    req    = M_DIV8;
    req_ok = 1'b1;
    if (cfg[SEL_B]) begin
      if (!cfg[ON_B])     req_ok = 1'b0;
      else if (cfg[LP_B]) req = M_LOWPWR;
      else                req = M_SUB;
    end else if (cfg[LP_B]) begin
      req_ok = 1'b0;
    end else if (cfg[D8_B]) begin
      req = M_DIV8;
    end else begin
      case (cfg[1:0])
        2'd0:    req = M_DIV1;
        2'd1:    req = M_DIV2;
        2'd2:    req = M_DIV4;
        default: req = M_DIV16;
      endcase
    end
  end
endmodule

// File: rtl/busclk_divider.sv
module busclk_divider
  import busclk_pkg::*;
#(
  parameter int MAX_SHIFT = 4,
  localparam int CNT_W = MAX_SHIFT
) (
  input  logic  clk,
  input  logic  rst,
  input  mode_e act,
  input  logic  sub_tick,
  input  logic  hold,
  input  logic  restart,
  output logic  wrap,
  output logic  bus_en
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  int unsigned      shift;

  always_comb begin
    case (act)
      M_DIV1:  shift = 0;
      M_DIV2:  shift = 1;
      M_DIV4:  shift = 2;
      M_DIV8:  shift = 3;
      default: shift = MAX_SHIFT;
    endcase
    lim = (CNT_W'(1) << shift) - CNT_W'(1);
  end

  always_comb begin
    if (hold)             wrap = 1'b0;
    else if (is_sub(act)) wrap = sub_tick;
    else                  wrap = (cnt == lim);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      bus_en <= 1'b0;
    end else begin
      bus_en <= wrap;
      if (restart || hold || is_sub(act) || cnt == lim) cnt <= '0;
      else                                              cnt <= cnt + 1'b1;
    end
  end

  AST_NO_BUS_IN_STOP: assert property (@(posedge clk) disable iff (rst)
    hold |=> !bus_en); // R10
  AST_SUB_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (is_sub(act) && !hold && sub_tick) |=> bus_en); // R4
endmodule

// File: rtl/busclk_ctrl.sv
module busclk_ctrl
  import busclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  mode_e            req,
  input  logic             req_ok,
  input  logic             main_stable,
  input  logic             sub_stable,
  input  logic             stop_req,
  input  logic             wrap,
  output logic [CFG_W-1:0] ctl,
  output mode_e            act,
  output logic             hold,
  output logic             restart,
  output logic             mode_match
);
  logic stopped;
  logic stop_entry;
  logic dst_ok;

  assign hold       = stopped | stop_req;
  assign stop_entry = stop_req & ~stopped;
  assign dst_ok     = is_sub(req) ? sub_stable : main_stable;
  assign restart    = req_ok && (req != act) && dst_ok && wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl        <= CFG_RST;
      act        <= M_DIV8;
      stopped    <= 1'b0;
      mode_match <= 1'b0;
    end else begin
      stopped    <= stop_req;
      mode_match <= req_ok && (req == act);
      if (cfg_wr) ctl <= cfg_wdata;
      if (stop_entry && !is_sub(act)) begin
        act       <= M_DIV8;
        ctl[D8_B] <= 1'b1;
      end else if (restart) begin
        act <= req;
      end
    end
  end

  AST_RESET_DIV8: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (act == M_DIV8 && ctl == CFG_RST)); // R1
  AST_MAIN_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!$stable(act) && !is_sub(act) && !$past(stop_req)) |-> $past(main_stable)); // R6
  AST_SUB_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!$stable(act) && is_sub(act)) |-> $past(sub_stable)); // R7
  AST_INVALID_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!req_ok && !stop_req) |=> $stable(act)); // R8
endmodule

// File: rtl/busclk_sel.sv
module busclk_sel
  import busclk_pkg::*;
#(
  parameter int MAX_SHIFT = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_wr,
  input  logic [5:0] cfg_wdata,
  output logic [5:0] cfg_rdata,
  input  logic       main_stable,
  input  logic       sub_stable,
  input  logic       sub_tick,
  input  logic       stop_req,
  output logic       bus_en,
  output logic       src_sub,
  output logic       main_en,
  output logic [2:0] act_mode,
  output logic       mode_match
);
  mode_e req;
  mode_e act;
  logic  req_ok;
  logic  hold;
  logic  restart;
  logic  wrap;

  busclk_mode_dec u_dec (
    .cfg    (cfg_rdata),
    .req    (req),
    .req_ok (req_ok)
  );

  busclk_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .cfg_wr      (cfg_wr),
    .cfg_wdata   (cfg_wdata),
    .req         (req),
    .req_ok      (req_ok),
    .main_stable (main_stable),
    .sub_stable  (sub_stable),
    .stop_req    (stop_req),
    .wrap        (wrap),
    .ctl         (cfg_rdata),
    .act         (act),
    .hold        (hold),
    .restart     (restart),
    .mode_match  (mode_match)
  );

  busclk_divider #(.MAX_SHIFT(MAX_SHIFT)) u_div (
    .clk      (clk),
    .rst      (rst),
    .act      (act),
    .sub_tick (sub_tick),
    .hold     (hold),
    .restart  (restart),
    .wrap     (wrap),
    .bus_en   (bus_en)
  );

  assign act_mode = act;
  assign src_sub  = is_sub(act);
  assign main_en  = (act != M_LOWPWR);

  AST_MAIN_OFF_ONLY_SUB: assert property (@(posedge clk) disable iff (rst)
    !main_en |-> src_sub); // R5
endmodule

// File: tb/sim_busclk_sel.sv
module sim_busclk_sel;
  localparam int CLK_PER = 10;
  localparam int SUB_PER = 20;
  localparam int WD_CYC  = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_wr = 1'b0;
  logic [5:0] cfg_wdata = '0;
  logic [5:0] cfg_rdata;
  logic       main_stable = 1'b1;
  logic       sub_stable = 1'b1;
  logic       sub_tick = 1'b0;
  logic       stop_req = 1'b0;
  logic       bus_en, src_sub, main_en, mode_match;
  logic [2:0] act_mode;

  int checks = 0;
  int errors = 0;

  always #(CLK_PER/2) clk = ~clk;

  busclk_sel u0 (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .main_stable(main_stable), .sub_stable(sub_stable),
    .sub_tick(sub_tick), .stop_req(stop_req), .bus_en(bus_en),
    .src_sub(src_sub), .main_en(main_en), .act_mode(act_mode),
    .mode_match(mode_match)
  );

  initial begin
    forever begin
      repeat (SUB_PER-1) @(negedge clk);
      sub_tick = 1'b1;
      @(negedge clk);
      sub_tick = 1'b0;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_cfg(input logic [5:0] v);
    cfg_wdata = v;
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic period(output int n);
    while (!bus_en) @(negedge clk);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!bus_en);
  endtask

  task automatic t_reset;
    int p;
    wait_cyc(2);
    check("R1 rdata", cfg_rdata, 6'b000100);
    check("R1 mode", act_mode, 3);
    check("R1 src_sub", src_sub, 0);
    check("R1 main_en", main_en, 1);
    period(p);
    check("R1 period", p, 8);
  endtask

  task automatic t_dividers;
    int p;
    int exp_p[4] = '{1, 2, 4, 16};
    int exp_m[4] = '{0, 1, 2, 4};
    for (int c = 0; c < 4; c++) begin
      write_cfg(6'(c));
      wait_cyc(40);
      check("R2 mode", act_mode, exp_m[c]);
      period(p);
      check("R2 period", p, exp_p[c]);
    end
  endtask

  task automatic t_override;
    int p;
    write_cfg(6'b000111);
    wait_cyc(40);
    check("R3 mode", act_mode, 3);
    period(p);
    check("R3 period", p, 8);
    write_cfg(6'b000101);
    wait_cyc(20);
    period(p);
    check("R3 period code1", p, 8);
  endtask

  task automatic t_wrap;
    int n;
    int p;
    write_cfg(6'b000011);
    wait_cyc(40);
    while (!bus_en) @(negedge clk);
    n = 0;
    repeat (5) begin @(negedge clk); n++; end
    write_cfg(6'b000001);
    n++;
    while (!bus_en) begin @(negedge clk); n++; end
    check("R9 interval in progress", n, 16);
    period(p);
    check("R9 new period", p, 2);
  endtask

  task automatic t_main_wait;
    int p;
    write_cfg(6'b000100);
    wait_cyc(40);
    main_stable = 1'b0;
    write_cfg(6'b000010);
    wait_cyc(60);
    check("R6 held mode", act_mode, 3);
    check("R12 no match", mode_match, 0);
    period(p);
    check("R6 held period", p, 8);
    main_stable = 1'b1;
    wait_cyc(30);
    check("R6 applied", act_mode, 2);
    check("R12 match", mode_match, 1);
    period(p);
    check("R6 period", p, 4);
  endtask

  task automatic t_sub;
    int p;
    sub_stable = 1'b0;
    write_cfg(6'b110111);
    wait_cyc(60);
    check("R7 held mode", act_mode, 2);
    check("R7 held src", src_sub, 0);
    sub_stable = 1'b1;
    wait_cyc(60);
    check("R7 applied", act_mode, 5);
    check("R4 src_sub", src_sub, 1);
    check("R4 main_en", main_en, 1);
    period(p);
    check("R4 period", p, SUB_PER);
    while (!sub_tick) @(negedge clk);
    check("R4 not yet", bus_en, 0);
    @(negedge clk);
    check("R4 follows tick", bus_en, 1);
  endtask

  task automatic t_lowpwr;
    int p;
    write_cfg(6'b111000);
    wait_cyc(60);
    check("R5 mode", act_mode, 6);
    check("R5 main_en", main_en, 0);
    check("R5 src_sub", src_sub, 1);
    period(p);
    check("R5 period", p, SUB_PER);
  endtask

  task automatic t_invalid;
    write_cfg(6'b100000);
    wait_cyc(60);
    check("R8 kept sel-no-on", act_mode, 6);
    check("R8 no match", mode_match, 0);
    write_cfg(6'b001000);
    wait_cyc(60);
    check("R8 kept lp-no-sel", act_mode, 6);
    check("R8 no match 2", mode_match, 0);
    write_cfg(6'b000001);
    wait_cyc(60);
    check("R8 recovered", act_mode, 1);
    check("R8 main_en", main_en, 1);
  endtask

  task automatic t_stop_main;
    int hits;
    int p;
    stop_req = 1'b1;
    hits = 0;
    repeat (12) begin
      @(negedge clk);
      if (bus_en) hits++;
    end
    check("R10 no pulses", hits, 0);
    check("R10 override bit", cfg_rdata[2], 1);
    check("R10 mode", act_mode, 3);
    stop_req = 1'b0;
    wait_cyc(20);
    period(p);
    check("R10 resume period", p, 8);
  endtask

  task automatic t_stop_sub;
    int p;
    write_cfg(6'b110000);
    wait_cyc(60);
    check("R11 pre mode", act_mode, 5);
    stop_req = 1'b1;
    wait_cyc(12);
    stop_req = 1'b0;
    wait_cyc(2);
    check("R11 rdata", cfg_rdata, 6'b110000);
    check("R11 mode", act_mode, 5);
    period(p);
    check("R11 period", p, SUB_PER);
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_dividers();
    t_override();
    t_wrap();
    t_main_wait();
    t_sub();
    t_lowpwr();
    t_invalid();
    t_stop_main();
    t_stop_sub();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule